// File: doc/BRIEF.md
# Stream Receive Packet Buffer

This block accepts packets from a 32-bit AXI4-Stream source and holds them until a CPU collects them through a small register window. Every accepted beat places its word in a data FIFO. The beat that carries `tlast` also places an entry in a separate length queue. That entry holds the packet's byte count, which is the sum of the `tkeep` bits set across its beats, and the `tdest` value seen on that last beat.

Software drains one packet at a time. A read of the length register takes the oldest queued entry. It unlocks that packet's words for reading and latches its destination tag into the destination register. Data reads then pop the unlocked words in arrival order. Reads made outside this order raise one-cycle error pulses, and so does a read from an empty store. A keyed write to the flush register discards everything held. Every event output is a single-cycle pulse meant for a separate interrupt collector.

Register byte offsets: flush 0x18, occupancy 0x1C, data 0x20, length 0x24, destination 0x30. Read data is combinational and valid in the cycle that `reg_rd_en` is high. The side effects of an access, and the event pulses it causes, take effect at the end of that cycle.

Top module: `rx_pkt_buffer`

## Requirements
- R1: After reset: occupancy reads 1, `s_tready` is high, every event output is low, and the length and destination registers read 0.
- R2: Occupancy (0x1C) reads the number of words held in the data FIFO plus one. Words still locked count, and so do words already unlocked.
- R3: A length read (0x24) returns the byte count of the oldest complete packet. The count is the sum of the `tkeep` bits set over its beats. The read unlocks ceil(count/4) words. A length read with no complete packet queued returns 0 and has no effect.
- R4: Data reads (0x20) return the unlocked words in the order they arrived, one word per read, and each read removes that word.
- R5: The destination register (0x30) returns the `tdest` sampled on the last beat of the packet whose length was read most recently.
- R6: A data read while no unlocked word remains returns 0 and removes nothing. It pulses `ev_over_read` in the next cycle.
- R7: A data read while the data FIFO holds no word at all pulses `ev_underrun` in the next cycle.
- R8: A length read while unlocked words of the previous packet remain pulses `ev_under_read` in the next cycle. It discards those leftover words and unlocks the next packet.
- R9: Writing exactly 0x000000A5 to 0x18 empties both the data FIFO and the length queue, and clears the destination register. It pulses `ev_reset_done` in the next cycle. Any other value written there changes nothing.
- R10: `ev_rx_done` pulses in the cycle after a beat with `tlast` is accepted.
- R11: `s_tready` is low while the data FIFO or the length queue is full. No beat is taken or lost while it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_tvalid | input | 1 | Stream beat valid |
| s_tready | output | 1 | Stream beat accepted when high with s_tvalid |
| s_tdata | input | 32 | Stream data word |
| s_tkeep | input | 4 | Valid-byte mask, contiguous from bit 0 |
| s_tlast | input | 1 | Last beat of a packet |
| s_tdest | input | DEST_W | Packet destination tag |
| reg_rd_en | input | 1 | Register read strobe |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| ev_rx_done | output | 1 | Packet fully received pulse |
| ev_under_read | output | 1 | Length read with words left pulse |
| ev_over_read | output | 1 | Data read without unlocked word pulse |
| ev_underrun | output | 1 | Data read from empty store pulse |
| ev_reset_done | output | 1 | Flush complete pulse |

## Verification
The bench builds the block with an 8-word data FIFO, a 2-entry length queue and 4-bit tags. With those sizes, one 8-word packet fills the data store and two 1-word packets fill the length queue. Both back-pressure conditions are therefore reached in a few dozen cycles. The same short packets also cover under-read discards, locked-data over-reads and flushes with words still held.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
    localparam int          REG_AW    = 6;
    localparam logic [5:0]  OFS_FLUSH = 6'h18;
    localparam logic [5:0]  OFS_FILL  = 6'h1C;
    localparam logic [5:0]  OFS_WORD  = 6'h20;
    localparam logic [5:0]  OFS_SIZE  = 6'h24;
    localparam logic [5:0]  OFS_TAG   = 6'h30;
    localparam logic [31:0] FLUSH_KEY = 32'h0000_00A5;
endpackage

// File: rtl/rxb_fifo.sv
module rxb_fifo #(
    parameter  int W     = 32,
    parameter  int DEPTH = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    input  logic          drop_en,
    input  logic [CW-1:0] drop_n,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t      st_q, st_d;
    logic [W-1:0]  mem [DEPTH];
    logic [CW-1:0] dec;

    always_comb begin
        st_d = st_q;
        dec  = pop ? CW'(1) : (drop_en ? drop_n : '0);
        if (clr) begin
            st_d = '0;
        end else begin
            if (push)         st_d.wr = st_q.wr + 1'b1;
            if (pop)          st_d.rd = st_q.rd + 1'b1;
            else if (drop_en) st_d.rd = st_q.rd + drop_n[AW-1:0];
            st_d.cnt = st_q.cnt + CW'(push) - dec;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push && !clr) mem[st_q.wr] <= din;
    end

    assign dout  = mem[st_q.rd];
    assign count = st_q.cnt;
    assign full  = (st_q.cnt == CW'(DEPTH));
    assign empty = (st_q.cnt == '0);

    // R11: the producer never writes into a full store
    p_push_not_full_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !clr) |-> !full);
    // R4: the consumer never pops an empty store
    p_pop_not_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !clr) |-> !empty);
    // R8: a discard never removes more words than are held
    p_drop_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_en && !clr) |-> (drop_n <= st_q.cnt));
endmodule

// File: rtl/rxb_ingress.sv
module rxb_ingress #(
    parameter  int DEST_W = 4,
    parameter  int LEN_W  = 16,
    localparam int ENT_W  = DEST_W + LEN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              s_tvalid,
    output logic              s_tready,
    input  logic [31:0]       s_tdata,
    input  logic [3:0]        s_tkeep,
    input  logic              s_tlast,
    input  logic [DEST_W-1:0] s_tdest,
    input  logic              data_full,
    input  logic              len_full,
    output logic              word_push,
    output logic [31:0]       word_data,
    output logic              len_push,
    output logic [ENT_W-1:0]  len_entry,
    output logic              rx_done
);
    typedef struct packed {
        logic [LEN_W-1:0] bytes;
        logic             done;
    } ing_st_t;

    ing_st_t          st_q, st_d;
    logic             beat;
    logic [LEN_W-1:0] bytes_now;

    always_comb begin
        s_tready  = !data_full && !len_full;
        beat      = s_tvalid && s_tready;
        bytes_now = st_q.bytes + LEN_W'($countones(s_tkeep));
        st_d      = st_q;
        st_d.done = beat && s_tlast;
        if (clr)       st_d.bytes = '0;
        else if (beat) st_d.bytes = s_tlast ? '0 : bytes_now;
        word_push = beat;
        word_data = s_tdata;
        len_push  = beat && s_tlast;
        len_entry = {s_tdest, bytes_now};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rx_done = st_q.done;
endmodule

// File: rtl/rxb_readout.sv
module rxb_readout
    import rxb_pkg::*;
#(
    parameter  int CNT_W  = 5,
    parameter  int DEST_W = 4,
    parameter  int LEN_W  = 16,
    localparam int RW     = LEN_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_rd_en,
    input  logic              reg_wr_en,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [31:0]       word_head,
    input  logic [CNT_W-1:0]  word_count,
    input  logic              word_empty,
    input  logic [LEN_W-1:0]  len_head,
    input  logic [DEST_W-1:0] tag_head,
    input  logic              len_empty,
    output logic              word_pop,
    output logic              word_drop_en,
    output logic [CNT_W-1:0]  word_drop_n,
    output logic              len_pop,
    output logic              flush,
    output logic              ev_under_read,
    output logic              ev_over_read,
    output logic              ev_underrun,
    output logic              ev_reset_done
);
    typedef struct packed {
        logic [RW-1:0]     rem;
        logic [DEST_W-1:0] tag;
        logic              under_rd;
        logic              over_rd;
        logic              underrun;
        logic              rst_done;
    } rd_st_t;

    rd_st_t         st_q, st_d;
    logic           rd_word, rd_size;
    logic [LEN_W:0] rounded;

    always_comb begin
        rd_word = reg_rd_en && (reg_addr == OFS_WORD);
        rd_size = reg_rd_en && (reg_addr == OFS_SIZE);
        flush   = reg_wr_en && (reg_addr == OFS_FLUSH) && (reg_wdata == FLUSH_KEY);
        rounded = {1'b0, len_head} + (LEN_W+1)'(3);

        st_d          = st_q;
        st_d.under_rd = 1'b0;
        st_d.over_rd  = 1'b0;
        st_d.underrun = 1'b0;
        st_d.rst_done = 1'b0;
        word_pop      = 1'b0;
        word_drop_en  = 1'b0;
        word_drop_n   = CNT_W'(st_q.rem);
        len_pop       = 1'b0;

        if (flush) begin
            st_d.rem      = '0;
            st_d.tag      = '0;
            st_d.rst_done = 1'b1;
        end else begin
            if (rd_word) begin
                if (st_q.rem == '0) begin
                    st_d.over_rd = 1'b1;
                end else begin
                    word_pop = 1'b1;
                    st_d.rem = st_q.rem - 1'b1;
                end
                if (word_empty) st_d.underrun = 1'b1;
            end
            if (rd_size && !len_empty) begin
                if (st_q.rem != '0) begin
                    st_d.under_rd = 1'b1;
                    word_drop_en  = 1'b1;
                end
                len_pop  = 1'b1;
                st_d.rem = rounded[LEN_W:2];
                st_d.tag = tag_head;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_rd_en) begin
            unique case (reg_addr)
                OFS_FILL: reg_rdata = 32'(word_count) + 32'd1;
                OFS_WORD: reg_rdata = (st_q.rem != '0) ? word_head : '0;
                OFS_SIZE: reg_rdata = len_empty ? '0 : 32'(len_head);
                OFS_TAG:  reg_rdata = 32'(st_q.tag);
                default:  reg_rdata = '0;
            endcase
        end
    end

    assign ev_under_read = st_q.under_rd;
    assign ev_over_read  = st_q.over_rd;
    assign ev_underrun   = st_q.underrun;
    assign ev_reset_done = st_q.rst_done;

    // R4: every unlocked word is still held in the data store
    p_unlocked_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.rem != '0) |-> (32'(word_count) >= 32'(st_q.rem)));
    // R6: a data read with nothing unlocked is flagged next cycle
    p_over_read_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_word && !flush && st_q.rem == '0) |=> ev_over_read);
    // R9: a keyed flush leaves the store empty and reports completion
    p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (word_count == '0 && st_q.rem == '0 && ev_reset_done));
endmodule

// File: rtl/rx_pkt_buffer.sv
module rx_pkt_buffer
    import rxb_pkg::*;
#(
    parameter  int DATA_DEPTH = 16,
    parameter  int LEN_DEPTH  = 4,
    parameter  int DEST_W     = 4,
    parameter  int LEN_W      = 16,
    localparam int DCW        = $clog2(DATA_DEPTH) + 1,
    localparam int LCW        = $clog2(LEN_DEPTH) + 1,
    localparam int ENT_W      = DEST_W + LEN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_tvalid,
    output logic              s_tready,
    input  logic [31:0]       s_tdata,
    input  logic [3:0]        s_tkeep,
    input  logic              s_tlast,
    input  logic [DEST_W-1:0] s_tdest,
    input  logic              reg_rd_en,
    input  logic              reg_wr_en,
    input  logic [5:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              ev_rx_done,
    output logic              ev_under_read,
    output logic              ev_over_read,
    output logic              ev_underrun,
    output logic              ev_reset_done
);
    logic             flush;
    logic             word_push, word_pop, word_drop_en;
    logic [DCW-1:0]   word_drop_n, word_count;
    logic [31:0]      word_data, word_head;
    logic             word_full, word_empty;
    logic             len_push, len_pop, len_full, len_empty;
    logic [ENT_W-1:0] len_entry, len_head_ent;
    logic [LCW-1:0]   len_count;

    rxb_ingress #(.DEST_W(DEST_W), .LEN_W(LEN_W)) ingress_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (flush),
        .s_tvalid  (s_tvalid),
        .s_tready  (s_tready),
        .s_tdata   (s_tdata),
        .s_tkeep   (s_tkeep),
        .s_tlast   (s_tlast),
        .s_tdest   (s_tdest),
        .data_full (word_full),
        .len_full  (len_full),
        .word_push (word_push),
        .word_data (word_data),
        .len_push  (len_push),
        .len_entry (len_entry),
        .rx_done   (ev_rx_done)
    );

    rxb_fifo #(.W(32), .DEPTH(DATA_DEPTH)) word_store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (flush),
        .push    (word_push),
        .din     (word_data),
        .pop     (word_pop),
        .drop_en (word_drop_en),
        .drop_n  (word_drop_n),
        .dout    (word_head),
        .count   (word_count),
        .full    (word_full),
        .empty   (word_empty)
    );

    rxb_fifo #(.W(ENT_W), .DEPTH(LEN_DEPTH)) len_queue_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (flush),
        .push    (len_push),
        .din     (len_entry),
        .pop     (len_pop),
        .drop_en (1'b0),
        .drop_n  ('0),
        .dout    (len_head_ent),
        .count   (len_count),
        .full    (len_full),
        .empty   (len_empty)
    );

    rxb_readout #(.CNT_W(DCW), .DEST_W(DEST_W), .LEN_W(LEN_W)) readout_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_rd_en     (reg_rd_en),
        .reg_wr_en     (reg_wr_en),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .word_head     (word_head),
        .word_count    (word_count),
        .word_empty    (word_empty),
        .len_head      (len_head_ent[LEN_W-1:0]),
        .tag_head      (len_head_ent[ENT_W-1:LEN_W]),
        .len_empty     (len_empty),
        .word_pop      (word_pop),
        .word_drop_en  (word_drop_en),
        .word_drop_n   (word_drop_n),
        .len_pop       (len_pop),
        .flush         (flush),
        .ev_under_read (ev_under_read),
        .ev_over_read  (ev_over_read),
        .ev_underrun   (ev_underrun),
        .ev_reset_done (ev_reset_done)
    );

    // R11: with room in both stores the stream is never stalled
    p_ready_with_room_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(word_count) < DATA_DEPTH && 32'(len_count) < LEN_DEPTH) |-> s_tready);
    // R3: a queued length always has its words already stored
    p_len_has_words_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !len_empty |-> !word_empty);
endmodule

// File: tb/rx_pkt_buffer_tb.sv
module rx_pkt_buffer_tb_top;
    import rxb_pkg::*;

    localparam int DATA_DEPTH = 8;
    localparam int LEN_DEPTH  = 2;
    localparam int DEST_W     = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              s_tvalid = 1'b0, s_tready, s_tlast = 1'b0;
    logic [31:0]       s_tdata = '0;
    logic [3:0]        s_tkeep = '0;
    logic [DEST_W-1:0] s_tdest = '0;
    logic              reg_rd_en = 1'b0, reg_wr_en = 1'b0;
    logic [5:0]        reg_addr = '0;
    logic [31:0]       reg_wdata = '0, reg_rdata;
    logic              ev_rx_done, ev_under_read, ev_over_read, ev_underrun, ev_reset_done;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] exp_words[$];
    logic [31:0] exp_lens[$];
    logic [31:0] exp_tags[$];

    always #5 clk = ~clk;

    rx_pkt_buffer #(.DATA_DEPTH(DATA_DEPTH), .LEN_DEPTH(LEN_DEPTH), .DEST_W(DEST_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tdata(s_tdata), .s_tkeep(s_tkeep),
        .s_tlast(s_tlast), .s_tdest(s_tdest),
        .reg_rd_en(reg_rd_en), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ev_rx_done(ev_rx_done), .ev_under_read(ev_under_read), .ev_over_read(ev_over_read),
        .ev_underrun(ev_underrun), .ev_reset_done(ev_reset_done)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cpu_read(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd_en = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd_en = 1'b0;
    endtask

    task automatic cpu_write(input logic [5:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic send_beat(input logic [31:0] d, input logic [3:0] k, input logic l,
                             input logic [DEST_W-1:0] t);
        @(negedge clk);
        s_tvalid = 1'b1; s_tdata = d; s_tkeep = k; s_tlast = l; s_tdest = t;
        #1;
        while (!s_tready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        s_tvalid = 1'b0; s_tlast = 1'b0;
    endtask

    // driver: sends a packet and records what the reader must later see
    task automatic send_pkt(input int nw, input logic [3:0] last_keep,
                            input logic [DEST_W-1:0] t, input logic [31:0] base);
        for (int i = 0; i < nw; i++) begin
            exp_words.push_back(base + i);
            send_beat(base + i, (i == nw - 1) ? last_keep : 4'hF, i == nw - 1, t);
        end
        chk(ev_rx_done === 1'b1, "R10 rx_done after last beat", 32'(ev_rx_done), 1);
        exp_lens.push_back(32'(4 * (nw - 1) + $countones(last_keep)));
        exp_tags.push_back(32'(t));
    endtask

    task automatic check_occ(input logic [31:0] e, input string req);
        logic [31:0] d;
        cpu_read(OFS_FILL, d);
        chk(d === e, req, d, e);
    endtask

    // monitor side: pops the expected items and compares them with the reads
    task automatic read_size_tag(output int nwords);
        logic [31:0] d, el, et;
        el = exp_lens.pop_front();
        et = exp_tags.pop_front();
        cpu_read(OFS_SIZE, d);
        chk(d === el, "R3 length value", d, el);
        cpu_read(OFS_TAG, d);
        chk(d === et, "R5 destination tag", d, et);
        nwords = int'((el + 3) >> 2);
    endtask

    task automatic read_word();
        logic [31:0] d, e;
        e = exp_words.pop_front();
        cpu_read(OFS_WORD, d);
        chk(d === e, "R4 data word order", d, e);
        chk(!ev_over_read && !ev_underrun, "R4 no error on valid read",
            {30'd0, ev_over_read, ev_underrun}, 0);
    endtask

    task automatic read_frame();
        int nw;
        read_size_tag(nw);
        for (int i = 0; i < nw; i++) read_word();
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : stim
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk); #1;
        chk(s_tready === 1'b1, "R1 tready after reset", 32'(s_tready), 1);
        chk({ev_rx_done, ev_under_read, ev_over_read, ev_underrun, ev_reset_done} === 5'b0,
            "R1 events low", 32'({ev_rx_done, ev_under_read, ev_over_read, ev_underrun, ev_reset_done}), 0);
        check_occ(1, "R1 occupancy after reset");
        cpu_read(OFS_SIZE, d);
        chk(d === 0, "R1 length empty", d, 0);
        cpu_read(OFS_TAG, d);
        chk(d === 0, "R1 destination cleared", d, 0);

        // R2 R3 R4 R5: three-word packet, 10 bytes
        send_pkt(3, 4'b0011, 4'd5, 32'hA000_0000);
        check_occ(4, "R2 occupancy with locked words");
        read_frame();
        check_occ(1, "R2 occupancy after drain");

        // R6 R7: data read on empty store
        cpu_read(OFS_WORD, d);
        chk(d === 0, "R6 over-read returns zero", d, 0);
        chk(ev_over_read === 1'b1, "R6 over-read flag", 32'(ev_over_read), 1);
        chk(ev_underrun === 1'b1, "R7 underrun flag", 32'(ev_underrun), 1);

        // R6 with locked data present; R8 under-read
        send_pkt(2, 4'hF, 4'd9, 32'hB000_0000);
        send_pkt(1, 4'h1, 4'd2, 32'hC000_0000);
        cpu_read(OFS_WORD, d);
        chk(d === 0 && ev_over_read === 1'b1, "R6 locked data over-read", d, 0);
        chk(ev_underrun === 1'b0, "R7 no underrun when words held", 32'(ev_underrun), 0);
        check_occ(4, "R6 nothing removed by over-read");
        begin
            int nw;
            read_size_tag(nw);
            read_word();
        end
        cpu_read(OFS_SIZE, d);
        chk(d === 1, "R8 next length after under-read", d, 1);
        chk(ev_under_read === 1'b1, "R8 under-read flag", 32'(ev_under_read), 1);
        void'(exp_words.pop_front());
        void'(exp_lens.pop_front());
        void'(exp_tags.pop_front());
        check_occ(2, "R8 leftover discarded");
        cpu_read(OFS_TAG, d);
        chk(d === 2, "R5 tag follows new packet", d, 2);
        read_word();

        // R9 keyed flush
        send_pkt(2, 4'hF, 4'd7, 32'hD000_0000);
        cpu_write(OFS_FLUSH, 32'h0000_005A);
        chk(ev_reset_done === 1'b0, "R9 wrong key no reset_done", 32'(ev_reset_done), 0);
        check_occ(3, "R9 wrong key keeps data");
        cpu_write(OFS_FLUSH, FLUSH_KEY);
        chk(ev_reset_done === 1'b1, "R9 reset_done pulse", 32'(ev_reset_done), 1);
        exp_words.delete(); exp_lens.delete(); exp_tags.delete();
        check_occ(1, "R9 occupancy after flush");
        cpu_read(OFS_SIZE, d);
        chk(d === 0, "R9 length queue emptied", d, 0);

        // R11 data store full
        send_pkt(8, 4'hF, 4'd3, 32'hE000_0000);
        @(negedge clk);
        s_tvalid = 1'b1; s_tdata = 32'hDEAD_BEEF; s_tkeep = 4'hF; s_tlast = 1'b1;
        #1 chk(s_tready === 1'b0, "R11 tready low on full data", 32'(s_tready), 0);
        repeat (3) @(negedge clk);
        s_tvalid = 1'b0; s_tlast = 1'b0;
        check_occ(9, "R11 no beat taken while stalled");
        read_frame();

        // R11 length queue full
        send_pkt(1, 4'hF, 4'd1, 32'hF000_0000);
        send_pkt(1, 4'h7, 4'd4, 32'hF100_0000);
        @(negedge clk);
        s_tvalid = 1'b1; s_tlast = 1'b1;
        #1 chk(s_tready === 1'b0, "R11 tready low on full length queue", 32'(s_tready), 0);
        @(negedge clk);
        s_tvalid = 1'b0; s_tlast = 1'b0;
        read_frame();
        read_frame();
        check_occ(1, "R2 occupancy at end");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule